// File: doc/BRIEF.md
# Two-bank set-associative TLB lookup with random-way refill

The block translates a 32-bit virtual address through a translation lookaside buffer that software fills. The buffer is split into an instruction bank, which serves fetches, and a data bank, which serves loads and stores. Each bank has four ways and sixteen sets, and the set is chosen by the low bits of the virtual page number. An entry matches when its page number agrees and it is either global or tagged with the current process ID. A matched entry is then checked for kernel protection and validity. The lookup ends with a hit carrying a physical address and read/write/execute rights, with a fault carrying a vector offset, or with a miss.

When a lookup that is not marked as a debug probe fails to hit, the block prepares a software refill. It records the failing set and a suggested way in a selection register, and the access type, page number and process ID in a cause register. The suggested way comes from a 16-bit linear feedback shift register, and that register advances only on those failing lookups. A debug probe returns the same result but leaves all state alone. Entries are written through a simple load port that names bank, way, set and the two entry words.

Top module: `tlb_lookup_unit`

## Requirements
- R1: An entry holds a high word (page number in bits [31:13], process ID in bits [7:0]) and a low word (frame number in bits [31:13], global bit 4, valid bit 3, kernel bit 2, write bit 1, execute bit 0). The set is vaddr[16:13]. An entry matches when it has been loaded since reset, its page number equals vaddr[31:13], and either its global bit is set or its process ID equals `cur_pid`. When several ways match, the lowest-numbered way is used. A load overwrites the entry at the named bank, way and set.
- R2: The access type is coded 0 for read, 1 for write and 2 for execute. Execute lookups search bank 0 only (`ld_bank`=0); read and write lookups search bank 1 only.
- R3: On a hit, `rsp_paddr` is the frame number shifted left by 13, `rsp_perm_r` is 1 and `rsp_perm_w` equals the entry's write bit.
- R4: On a hit, `rsp_perm_x` is 1 only for a bank-0 lookup in which `cfg_exec_en` or the entry's execute bit is set; a data-bank lookup never grants execute.
- R5: A matched entry faults with `rsp_vec`=3 when `req_user`, `cfg_kprot_en` and the entry's kernel bit are all set; this check takes precedence over the valid check.
- R6: Otherwise a matched entry faults with `rsp_vec`=1 when `cfg_vchk_en` is set and the entry's valid bit is clear; with `cfg_vchk_en` clear, an entry whose valid bit is clear still hits.
- R7: A lookup that finds no match reports hit 0, fault 0 and `rsp_vec`=0. Whenever there is no hit, `rsp_paddr` and all three permissions are 0, and hit and fault are never both 1.
- R8: A request sampled at one rising edge produces `rsp_valid` high for exactly one cycle after the second rising edge; one request gives one response.
- R9: The refill register resets to 0xCCCC. On every non-debug lookup without a hit (miss or fault) it steps once: it shifts right by one and bit 15 takes the XOR of state bits 0, 2, 11 and 15. Hits and debug lookups do not step it.
- R10: On a non-debug lookup without a hit, `sel_reg` becomes the set in bits [3:0] and a way in bits [5:4], other bits 0; the way is the refill register's bits [1:0] before the step on a miss, and the matched way on a fault.
- R11: On a non-debug lookup without a hit, `cause_reg` becomes the process ID in bits [7:0], the access-type code in bits [9:8] and vaddr[31:13] in bits [31:13], other bits 0.
- R12: A lookup with `req_debug` set gives the same response but changes neither `sel_reg`, `cause_reg` nor the refill register.
- R13: After reset no entry is loaded, `rsp_valid` is 0 and `sel_reg` and `cause_reg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write one entry this cycle |
| ld_bank | input | 1 | Bank to write: 0 instruction, 1 data |
| ld_way | input | 2 | Way to write |
| ld_idx | input | 4 | Set to write |
| ld_hi | input | 32 | High entry word |
| ld_lo | input | 32 | Low entry word |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_user | input | 1 | Access is from user mode |
| req_debug | input | 1 | Probe without side effects |
| cur_pid | input | 8 | Current process ID |
| cfg_kprot_en | input | 1 | Enable kernel-page protection |
| cfg_vchk_en | input | 1 | Enable the valid-bit check |
| cfg_exec_en | input | 1 | Grant execute on every instruction-bank hit |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Matched entry refused access |
| rsp_vec | output | 2 | Fault vector offset: 0 miss, 1 invalid, 3 kernel |
| rsp_paddr | output | 32 | Physical address on a hit |
| rsp_perm_r | output | 1 | Read granted |
| rsp_perm_w | output | 1 | Write granted |
| rsp_perm_x | output | 1 | Execute granted |
| sel_reg | output | 32 | Refill selection: set and suggested way |
| cause_reg | output | 32 | Refill cause: page, access type, process ID |

## Verification
A wrong refill register would first show as a wrong way field in `sel_reg` on the next failing lookup, and a missed or extra step shifts every later suggested way, so a run of consecutive misses exposes it within a few responses. A lost entry, a wrong bank choice or a broken process-ID comparison flips hit into miss on the very response to that lookup, two edges after the request. A debug probe that leaks state shows in `sel_reg` or `cause_reg` at once, or as a shifted way on the following miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2
   } acc_kind_e;

   // low-word flag positions
   localparam int LO_GLOBAL = 4;
   localparam int LO_VALID  = 3;
   localparam int LO_KERNEL = 2;
   localparam int LO_WRITE  = 1;
   localparam int LO_EXEC   = 0;

   // cause register: access type field position
   localparam int CAUSE_KIND_LSB = 8;

   // fault vector offsets
   localparam logic [1:0] VEC_NONE    = 2'd0;
   localparam logic [1:0] VEC_INVALID = 2'd1;
   localparam logic [1:0] VEC_KERNEL  = 2'd3;

   // bank numbering
   localparam logic BANK_INSN = 1'b0;
   localparam logic BANK_DATA = 1'b1;

endpackage

// File: rtl/tlb_rand_lfsr.sv
module tlb_rand_lfsr #(
   parameter int          W    = 16,
   parameter logic [W-1:0] POLY = 16'h8805,
   parameter logic [W-1:0] SEED = 16'hCCCC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] state
);

   generate
      if (W < 2) begin : g_bad_width
         $error("tlb_rand_lfsr: W must be at least 2");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("tlb_rand_lfsr: seed must be non-zero");
      end
   endgenerate

   logic feedback;
   assign feedback = ^(state & POLY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= {feedback, state[W-1:1]};
   end

   // R9: state is frozen unless a refill step is requested
   p_lfsr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(state));

   // R9: a maximal-length style register never reaches the all-zero lock-up state
   p_lfsr_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
   import tlb_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int PAGE_SHIFT = 13,
   parameter int PID_W      = 8,
   parameter int NUM_WAYS   = 4,
   parameter int NUM_SETS   = 16,
   localparam int WAY_W     = $clog2(NUM_WAYS),
   localparam int IDX_W     = $clog2(NUM_SETS),
   localparam int VPN_W     = WORD_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_hi,
   input  logic [WORD_W-1:0] wr_lo,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [VPN_W-1:0]  rd_vpn,
   input  logic [PID_W-1:0]  rd_pid,
   output logic              hit,
   output logic [WAY_W-1:0]  hit_way,
   output logic [WORD_W-1:0] hit_lo
);

   logic [NUM_WAYS-1:0] way_hit;
   logic [WORD_W-1:0]   way_lo [NUM_WAYS];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [WORD_W-1:0]   hi_m [NUM_SETS];
      logic [WORD_W-1:0]   lo_m [NUM_SETS];
      logic [NUM_SETS-1:0] loaded;
      logic                wr_here;
      logic [WORD_W-1:0]   cur_hi;

      assign wr_here = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk) begin
         if (wr_here) begin
            hi_m[wr_idx] <= wr_hi;
            lo_m[wr_idx] <= wr_lo;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       loaded         <= '0;
         else if (wr_here) loaded[wr_idx] <= 1'b1;
      end

      assign cur_hi     = hi_m[rd_idx];
      assign way_lo[w]  = lo_m[rd_idx];
      assign way_hit[w] = loaded[rd_idx]
                       && (cur_hi[WORD_W-1:PAGE_SHIFT] == rd_vpn)
                       && (way_lo[w][LO_GLOBAL] || (cur_hi[PID_W-1:0] == rd_pid));
   end

   // lowest-numbered matching way wins
   always_comb begin
      hit     = |way_hit;
      hit_way = '0;
      hit_lo  = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (way_hit[w]) begin
            hit_way = WAY_W'(w);
            hit_lo  = way_lo[w];
         end
      end
   end

endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
   import tlb_pkg::*;
#(
   parameter int           WORD_W     = 32,
   parameter int           PAGE_SHIFT = 13,
   parameter int           PID_W      = 8,
   parameter int           NUM_WAYS   = 4,
   parameter int           NUM_SETS   = 16,
   parameter int           RND_W      = 16,
   parameter logic [15:0]  RND_POLY   = 16'h8805,
   parameter logic [15:0]  RND_SEED   = 16'hCCCC,
   localparam int          WAY_W      = $clog2(NUM_WAYS),
   localparam int          IDX_W      = $clog2(NUM_SETS),
   localparam int          VPN_W      = WORD_W - PAGE_SHIFT,
   localparam int          NUM_BANKS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              ld_bank,
   input  logic [WAY_W-1:0]  ld_way,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [WORD_W-1:0] ld_hi,
   input  logic [WORD_W-1:0] ld_lo,
   input  logic              req_valid,
   input  logic [WORD_W-1:0] req_vaddr,
   input  logic [1:0]        req_kind,
   input  logic              req_user,
   input  logic              req_debug,
   input  logic [PID_W-1:0]  cur_pid,
   input  logic              cfg_kprot_en,
   input  logic              cfg_vchk_en,
   input  logic              cfg_exec_en,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_fault,
   output logic [1:0]        rsp_vec,
   output logic [WORD_W-1:0] rsp_paddr,
   output logic              rsp_perm_r,
   output logic              rsp_perm_w,
   output logic              rsp_perm_x,
   output logic [WORD_W-1:0] sel_reg,
   output logic [WORD_W-1:0] cause_reg
);

   generate
      if (PID_W > CAUSE_KIND_LSB) begin : g_bad_pid
         $error("tlb_lookup_unit: PID field overlaps the access-type field");
      end
      if (PAGE_SHIFT < CAUSE_KIND_LSB + 2) begin : g_bad_page
         $error("tlb_lookup_unit: page shift too small for the cause layout");
      end
      if (VPN_W < IDX_W) begin : g_bad_idx
         $error("tlb_lookup_unit: page number narrower than the set index");
      end
      if (IDX_W + WAY_W > WORD_W || RND_W < WAY_W) begin : g_bad_sel
         $error("tlb_lookup_unit: selection layout does not fit");
      end
      if (LO_GLOBAL >= PAGE_SHIFT) begin : g_bad_flags
         $error("tlb_lookup_unit: flag bits overlap the frame number");
      end
   endgenerate

   // ---------------- registered request ----------------
   logic              q_vld, q_user, q_dbg, q_kprot, q_vchk, q_xen;
   logic [WORD_W-1:0] q_vaddr;
   acc_kind_e         q_kind;
   logic [PID_W-1:0]  q_pid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_vld <= 1'b0;
      else        q_vld <= req_valid;
   end

   always_ff @(posedge clk) begin
      if (req_valid) begin
         q_vaddr <= req_vaddr;
         q_kind  <= acc_kind_e'(req_kind);
         q_user  <= req_user;
         q_dbg   <= req_debug;
         q_pid   <= cur_pid;
         q_kprot <= cfg_kprot_en;
         q_vchk  <= cfg_vchk_en;
         q_xen   <= cfg_exec_en;
      end
   end

   // ---------------- bank lookup ----------------
   logic [VPN_W-1:0] vpage;
   logic [IDX_W-1:0] set_idx;
   logic             bank_sel;

   assign vpage    = q_vaddr[WORD_W-1:PAGE_SHIFT];
   assign set_idx  = vpage[IDX_W-1:0];
   assign bank_sel = (q_kind == ACC_EXEC) ? BANK_INSN : BANK_DATA;

   logic              b_hit [NUM_BANKS];
   logic [WAY_W-1:0]  b_way [NUM_BANKS];
   logic [WORD_W-1:0] b_lo  [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      tlb_bank #(
         .WORD_W     (WORD_W),
         .PAGE_SHIFT (PAGE_SHIFT),
         .PID_W      (PID_W),
         .NUM_WAYS   (NUM_WAYS),
         .NUM_SETS   (NUM_SETS)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (ld_en && (ld_bank == 1'(b))),
         .wr_way  (ld_way),
         .wr_idx  (ld_idx),
         .wr_hi   (ld_hi),
         .wr_lo   (ld_lo),
         .rd_idx  (set_idx),
         .rd_vpn  (vpage),
         .rd_pid  (q_pid),
         .hit     (b_hit[b]),
         .hit_way (b_way[b]),
         .hit_lo  (b_lo[b])
      );
   end

   // ---------------- protection checks ----------------
   logic              matched, kern_flt, inval_flt, good;
   logic [WAY_W-1:0]  m_way;
   logic [WORD_W-1:0] m_lo;
   logic [1:0]        vec_nxt;

   assign matched   = b_hit[bank_sel];
   assign m_way     = b_way[bank_sel];
   assign m_lo      = b_lo[bank_sel];
   assign kern_flt  = matched && q_user && q_kprot && m_lo[LO_KERNEL];
   assign inval_flt = matched && !kern_flt && q_vchk && !m_lo[LO_VALID];
   assign good      = matched && !kern_flt && !inval_flt;
   assign vec_nxt   = kern_flt ? VEC_KERNEL : (inval_flt ? VEC_INVALID : VEC_NONE);

   // ---------------- refill bookkeeping ----------------
   logic             refill;
   logic [RND_W-1:0] rnd;
   logic [WAY_W-1:0] way_pick;

   assign refill   = q_vld && !good && !q_dbg;
   assign way_pick = matched ? m_way : rnd[WAY_W-1:0];

   tlb_rand_lfsr #(
      .W    (RND_W),
      .POLY (RND_POLY[RND_W-1:0]),
      .SEED (RND_SEED[RND_W-1:0])
   ) u_rnd (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (refill),
      .state (rnd)
   );

   logic [WORD_W-1:0] sel_nxt, cause_nxt;

   always_comb begin
      sel_nxt                       = '0;
      sel_nxt[IDX_W-1:0]            = set_idx;
      sel_nxt[IDX_W +: WAY_W]       = way_pick;
      cause_nxt                     = '0;
      cause_nxt[PID_W-1:0]          = q_pid;
      cause_nxt[CAUSE_KIND_LSB +: 2] = q_kind;
      cause_nxt[WORD_W-1:PAGE_SHIFT] = vpage;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_reg   <= '0;
         cause_reg <= '0;
      end else if (refill) begin
         sel_reg   <= sel_nxt;
         cause_reg <= cause_nxt;
      end
   end

   // ---------------- response ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_vec    <= VEC_NONE;
         rsp_paddr  <= '0;
         rsp_perm_r <= 1'b0;
         rsp_perm_w <= 1'b0;
         rsp_perm_x <= 1'b0;
      end else begin
         rsp_valid <= q_vld;
         if (q_vld) begin
            rsp_hit    <= good;
            rsp_fault  <= kern_flt || inval_flt;
            rsp_vec    <= vec_nxt;
            rsp_paddr  <= good ? {m_lo[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}} : '0;
            rsp_perm_r <= good;
            rsp_perm_w <= good && m_lo[LO_WRITE];
            rsp_perm_x <= good && (bank_sel == BANK_INSN) && (q_xen || m_lo[LO_EXEC]);
         end
      end
   end

   // ---------------- assertions ----------------
   // R8: every response pulse traces back to a request two edges earlier
   p_rsp_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid, 2));

   // R8: a single request yields a single-cycle pulse
   p_rsp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(req_valid)) |=> !rsp_valid);

   // R7: hit and fault exclude each other
   p_outcome_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_hit && rsp_fault));

   // R7: without a hit no address and no rights leave the block
   p_nohit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_perm_r && !rsp_perm_w && !rsp_perm_x));

   // R3: every hit grants read
   p_hit_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> rsp_perm_r);

   // R5: a fault carries one of the two fault vectors
   p_fault_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_vec == VEC_KERNEL || rsp_vec == VEC_INVALID));

   // R4: data-bank lookups never grant execute
   p_data_noexec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && q_kind != ACC_EXEC) |=> !rsp_perm_x);

   // R12: debug probes leave the refill registers untouched
   p_debug_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && q_dbg) |=> ($stable(sel_reg) && $stable(cause_reg)));

endmodule

// File: tb/sim_tlb_lookup_unit.sv
module sim_tlb_lookup_unit;

   typedef struct packed {
      logic        hit;
      logic        fault;
      logic [1:0]  vec;
      logic [31:0] pa;
      logic        r;
      logic        w;
      logic        x;
      logic [31:0] sel;
      logic [31:0] cause;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0, ld_bank = 1'b0;
   logic [1:0]  ld_way = '0;
   logic [3:0]  ld_idx = '0;
   logic [31:0] ld_hi = '0, ld_lo = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_user = 1'b0, req_debug = 1'b0;
   logic [7:0]  cur_pid = '0;
   logic        cfg_kprot_en = 1'b0, cfg_vchk_en = 1'b0, cfg_exec_en = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_fault, rsp_perm_r, rsp_perm_w, rsp_perm_x;
   logic [1:0]  rsp_vec;
   logic [31:0] rsp_paddr, sel_reg, cause_reg;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   tlb_lookup_unit u0 (
      .clk, .rst_n, .ld_en, .ld_bank, .ld_way, .ld_idx, .ld_hi, .ld_lo,
      .req_valid, .req_vaddr, .req_kind, .req_user, .req_debug, .cur_pid,
      .cfg_kprot_en, .cfg_vchk_en, .cfg_exec_en,
      .rsp_valid, .rsp_hit, .rsp_fault, .rsp_vec, .rsp_paddr,
      .rsp_perm_r, .rsp_perm_w, .rsp_perm_x, .sel_reg, .cause_reg
   );

   // ---------------- reference model ----------------
   logic [31:0] m_hi   [2][4][16];
   logic [31:0] m_lo   [2][4][16];
   bit          m_full [2][4][16];
   logic [15:0] m_rnd   = 16'hCCCC;
   logic [31:0] m_sel   = '0;
   logic [31:0] m_cause = '0;

   exp_t  exp_q [$];
   string tag_q [$];

   function automatic exp_t predict(input logic [31:0] va, input logic [1:0] kind,
                                    input logic user, input logic dbg, input logic [7:0] pid,
                                    input logic kp, input logic vc, input logic xe);
      exp_t        e;
      logic [18:0] vp;
      logic [3:0]  ix;
      int          bk, fw;
      bit          found, kf, vf, h;
      logic [31:0] lo;
      vp = va[31:13];
      ix = vp[3:0];
      bk = (kind == 2'd2) ? 0 : 1;
      found = 0;
      fw = 0;
      for (int w = 3; w >= 0; w--) begin
         if (m_full[bk][w][ix] && m_hi[bk][w][ix][31:13] == vp &&
             (m_lo[bk][w][ix][4] || m_hi[bk][w][ix][7:0] == pid)) begin
            found = 1;
            fw = w;
         end
      end
      lo = found ? m_lo[bk][fw][ix] : 32'h0;
      kf = found && kp && lo[2] && user;
      vf = found && !kf && vc && !lo[3];
      h  = found && !kf && !vf;
      e.hit   = h;
      e.fault = kf || vf;
      e.vec   = kf ? 2'd3 : (vf ? 2'd1 : 2'd0);
      e.pa    = h ? {lo[31:13], 13'b0} : 32'h0;
      e.r     = h;
      e.w     = h && lo[1];
      e.x     = h && (bk == 0) && (xe || lo[0]);
      if (!h && !dbg) begin
         m_sel   = {26'b0, (found ? 2'(fw) : m_rnd[1:0]), ix};
         m_cause = {vp, 3'b000, kind, pid};
         m_rnd   = {m_rnd[0] ^ m_rnd[2] ^ m_rnd[11] ^ m_rnd[15], m_rnd[15:1]};
      end
      e.sel   = m_sel;
      e.cause = m_cause;
      return e;
   endfunction

   // ---------------- driver ----------------
   task automatic do_load(input bit bank, input int way, input int idx,
                          input logic [31:0] hi, input logic [31:0] lo);
      @(negedge clk);
      ld_en = 1'b1; ld_bank = bank; ld_way = 2'(way); ld_idx = 4'(idx);
      ld_hi = hi;   ld_lo = lo;
      m_hi[bank][way][idx]   = hi;
      m_lo[bank][way][idx]   = lo;
      m_full[bank][way][idx] = 1;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic do_lookup(input logic [31:0] va, input logic [1:0] kind,
                            input logic user, input logic dbg, input logic [7:0] pid,
                            input logic kp, input logic vc, input logic xe,
                            input string tag);
      @(negedge clk);
      exp_q.push_back(predict(va, kind, user, dbg, pid, kp, vc, xe));
      tag_q.push_back(tag);
      req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = user;
      req_debug = dbg;  cur_pid = pid;  cfg_kprot_en = kp; cfg_vchk_en = vc;
      cfg_exec_en = xe;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [31:0] mk_hi(input logic [18:0] vpn, input logic [7:0] pid);
      return {vpn, 5'b0, pid};
   endfunction

   function automatic logic [31:0] mk_lo(input logic [18:0] pfn, input bit g, input bit v,
                                         input bit k, input bit w, input bit x);
      return {pfn, 8'b0, g, v, k, w, x};
   endfunction

   task automatic check_bit(input logic got, input logic want, input string what);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", what, got, want);
      end
   endtask

   // ---------------- monitor / scoreboard ----------------
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         exp_t  e, g;
         string t;
         g = '{hit: rsp_hit, fault: rsp_fault, vec: rsp_vec, pa: rsp_paddr,
               r: rsp_perm_r, w: rsp_perm_w, x: rsp_perm_x, sel: sel_reg, cause: cause_reg};
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R8: response with no pending request, actual hit=%0b expected none", rsp_hit);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (g !== e) begin
               errors++;
               $display("FAIL %s: actual hit=%0b flt=%0b vec=%0d pa=%h rwx=%0b%0b%0b sel=%h cause=%h expected hit=%0b flt=%0b vec=%0d pa=%h rwx=%0b%0b%0b sel=%h cause=%h",
                  t, g.hit, g.fault, g.vec, g.pa, g.r, g.w, g.x, g.sel, g.cause,
                  e.hit, e.fault, e.vec, e.pa, e.r, e.w, e.x, e.sel, e.cause);
            end
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int b = 0; b < 2; b++)
         for (int w = 0; w < 4; w++)
            for (int i = 0; i < 16; i++)
               m_full[b][w][i] = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13: reset state
      check_bit(rsp_valid, 1'b0, "R13 rsp_valid after reset");
      check_bit(sel_reg == 32'h0, 1'b1, "R13 sel_reg zero after reset");
      check_bit(cause_reg == 32'h0, 1'b1, "R13 cause_reg zero after reset");

      // R8 timing with an empty buffer: miss (R7, R13), way from seed (R10)
      do_lookup(32'h0000_2000, 2'd0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, "R8 R13 first miss");
      check_bit(rsp_valid, 1'b0, "R8 no pulse after first edge");
      @(negedge clk);
      check_bit(rsp_valid, 1'b1, "R8 pulse after second edge");
      @(negedge clk);
      check_bit(rsp_valid, 1'b0, "R8 pulse lasts one cycle");

      // R1 R3: data hit with matching PID
      do_load(1'b1, 2, 5, mk_hi(19'h00005, 8'h07), mk_lo(19'h12345, 0, 1, 0, 1, 0));
      do_lookup(32'h0000_A010, 2'd0, 1'b0, 1'b0, 8'h07, 1'b0, 1'b1, 1'b0, "R1 R3 pid hit read");
      do_lookup(32'h0000_A010, 2'd1, 1'b1, 1'b0, 8'h07, 1'b1, 1'b1, 1'b1, "R2 R4 write hit no exec");
      // R1: PID mismatch misses, cause records the write (R11)
      do_lookup(32'h0000_A010, 2'd1, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0, "R1 R11 pid mismatch miss");
      // R1: global entry ignores PID, no write right (R3)
      do_load(1'b1, 0, 5, mk_hi(19'h00015, 8'h03), mk_lo(19'h00ABC, 1, 1, 0, 0, 0));
      do_lookup(32'h0002_A000, 2'd0, 1'b0, 1'b0, 8'h09, 1'b0, 1'b0, 1'b0, "R1 R3 global hit");

      // R2: exec searches bank 0 only
      do_lookup(32'h0000_A000, 2'd2, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0, "R2 exec misses empty bank0");
      do_load(1'b0, 1, 5, mk_hi(19'h00005, 8'h07), mk_lo(19'h00777, 0, 1, 0, 0, 1));
      do_lookup(32'h0000_A000, 2'd2, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0, "R2 R4 exec hit via entry");
      do_load(1'b0, 3, 6, mk_hi(19'h00006, 8'h00), mk_lo(19'h00888, 1, 1, 0, 1, 0));
      do_lookup(32'h0000_C000, 2'd2, 1'b0, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0, "R4 exec hit no rights");
      do_lookup(32'h0000_C000, 2'd2, 1'b0, 1'b0, 8'h44, 1'b0, 1'b0, 1'b1, "R4 exec hit via config");
      do_lookup(32'h0000_C000, 2'd0, 1'b0, 1'b0, 8'h44, 1'b0, 1'b0, 1'b1, "R2 read misses bank1");

      // R5 R6: protection
      do_load(1'b1, 1, 7, mk_hi(19'h00007, 8'h00), mk_lo(19'h01234, 1, 0, 1, 1, 0));
      do_lookup(32'h0000_E000, 2'd0, 1'b1, 1'b0, 8'h01, 1'b1, 1'b1, 1'b0, "R5 R10 kernel fault wins");
      do_lookup(32'h0000_E000, 2'd1, 1'b0, 1'b0, 8'h01, 1'b1, 1'b1, 1'b0, "R6 R10 invalid fault");
      do_lookup(32'h0000_E000, 2'd1, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0, "R6 no check hits");
      do_lookup(32'h0000_E000, 2'd0, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, "R5 protect off hits");

      // R12: debug probes change nothing
      do_lookup(32'h1234_6000, 2'd1, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, "R12 debug miss");
      do_lookup(32'h0000_E000, 2'd0, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b0, "R12 debug fault");
      do_lookup(32'h0000_A010, 2'd0, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0, "R12 R9 hit after debug");

      // R9 R10 R11: run of misses walks the refill register
      for (int i = 0; i < 16; i++) begin
         do_lookup(32'h8000_0000 | (i << 13) | 32'h0000_0123, 2'(i % 3), 1'b0, 1'b0,
                   8'(i * 17), 1'b0, 1'b0, 1'b0, "R9 R10 R11 miss run");
      end

      // R1: overwrite replaces the entry; lowest way wins on double match
      do_load(1'b1, 2, 5, mk_hi(19'h00005, 8'h07), mk_lo(19'h54321, 0, 1, 0, 0, 0));
      do_lookup(32'h0000_A000, 2'd0, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0, "R1 overwrite hit");
      do_load(1'b1, 1, 5, mk_hi(19'h00005, 8'h00), mk_lo(19'h0BEEF, 1, 1, 0, 1, 0));
      do_lookup(32'h0000_A000, 2'd0, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0, "R1 lowest way wins");

      repeat (4) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R8: actual %0d responses missing expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule